// File: doc/BRIEF.md
# Carrier Activity Squelch Detector

This block turns sampled, asynchronous line indications from a bus transceiver into clean activity flags for its receive and transmit paths. It runs on a sample clock far faster than the bit rate. All time limits are parameters counted in sample-clock cycles: at a 100 MHz sample clock the defaults come to roughly 20 ns, 200 ns, 300 ns and 1 ms. The analog filtering and the comparators sit outside the block.

On the receive side, a comparator input reports that the averaged line level has passed the squelch threshold, and a second input carries the sampled line level. Receive activity begins when the comparator reports signal. It ends quickly when the line sits at its high level for a sustained run, so that dribble bits at the end of a packet are dropped. After that fast stop, the path stays closed only if the comparator drops within a long confirmation window. If the comparator is still reporting signal when the window expires, the path opens again. While the path is active, the receive output pair carries the line level. While it is inactive, both legs are held at zero.

On the transmit side, low pulses narrower than a glitch limit are ignored. A qualified low run starts transmit activity, and a separate idle timeout on the high level ends it.

Top module: `carrier_squelch_top`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `rx_active`, `tx_active`, `rx_pos` and `rx_neg` are all 0.
- R2: Each asynchronous input passes through two flops before any logic uses it. From idle, `rx_active` rises on the third clock edge after `rx_sig_async` goes to 1. A low on `tx_in_async` raises `tx_active` on clock edge `TX_MIN_LOW + 2`.
- R3: Receive activity starts when `rx_sig_async` is 1, meaning the averaged level has passed the squelch threshold.
- R4: While receive is active, `RX_OFF_CYC` consecutive synchronized samples of `rx_line_async` = 1 end receive activity. Shorter high runs leave it active.
- R5: After a fast turn-off, if `rx_sig_async` drops to 0 inside the window, receive stays inactive until `rx_sig_async` rises again.
- R6: After a fast turn-off, if `rx_sig_async` is still 1 after `RX_WIN_CYC` cycles, receive activity resumes.
- R7: While `rx_active` is 1, `rx_pos` equals the synchronized line level and `rx_neg` is its complement. While `rx_active` is 0, both are 0.
- R8: `tx_active` is set only after `TX_MIN_LOW` consecutive synchronized low samples of `tx_in_async`. Shorter low pulses have no effect.
- R9: While transmit is active, `TX_IDLE_CYC` consecutive synchronized high samples clear `tx_active`. A shorter high run, including one broken by a brief low, keeps it set.
- R10: Receive activity ends whenever `rx_sig_async` falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_sig_async | input | 1 | Comparator: 1 = averaged level past the squelch threshold |
| rx_line_async | input | 1 | Sampled receive line level, 1 = high (idle) level |
| tx_in_async | input | 1 | Sampled transmit input, 1 = high (idle) level |
| rx_active | output | 1 | Receive path qualified active |
| rx_pos | output | 1 | Receive output, true leg |
| rx_neg | output | 1 | Receive output, complement leg |
| tx_active | output | 1 | Transmit path qualified active |

## Verification
The assertions look only at the synchronized copies of the inputs. They assume that each input edge is settled two flops before any counter reacts to it, so an activity flag can only change after the matching synchronized level has been seen on the previous edge. The bench keeps to this by changing inputs only on the falling clock edge and holding each level for whole cycles. Every pulse width therefore reaches the counters as an exact number of synchronized samples. The bench also lets each path return to a known idle state before the next width in a sweep.

// File: rtl/csq_pkg.sv
package csq_pkg;

  typedef enum logic [1:0] {
    RXS_IDLE = 2'd0,
    RXS_ON   = 2'd1,
    RXS_HOLD = 2'd2
  } rx_state_t;

  // counter width able to hold values 0..lim
  function automatic int cnt_width(input int lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // a run of (cnt + 1) samples has reached the limit
  function automatic logic run_done(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/csq_sync2.sv
module csq_sync2 #(
  parameter int        WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/csq_rx_squelch.sv
module csq_rx_squelch
  import csq_pkg::*;
#(
  parameter int RX_OFF_CYC = 20,
  parameter int RX_WIN_CYC = 100000,
  localparam int OFF_W = cnt_width(RX_OFF_CYC),
  localparam int WIN_W = cnt_width(RX_WIN_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_s,
  input  logic             line_s,
  output logic             active,
  output logic             holding,
  output logic [WIN_W-1:0] win_cnt
);
  rx_state_t        state_q;
  logic [OFF_W-1:0] hi_q;
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RXS_IDLE;
      hi_q    <= '0;
      win_q   <= '0;
    end else begin
      unique case (state_q)
        RXS_IDLE: begin
          hi_q  <= '0;
          win_q <= '0;
          if (sig_s) state_q <= RXS_ON;
        end
        RXS_ON: begin
          if (!sig_s) begin
            state_q <= RXS_IDLE;
            hi_q    <= '0;
          end else if (line_s) begin
            if (run_done(32'(hi_q), RX_OFF_CYC)) begin
              state_q <= RXS_HOLD;
              hi_q    <= '0;
              win_q   <= '0;
            end else begin
              hi_q <= hi_q + 1'b1;
            end
          end else begin
            hi_q <= '0;
          end
        end
        RXS_HOLD: begin
          if (!sig_s) begin
            state_q <= RXS_IDLE;
            win_q   <= '0;
          end else if (run_done(32'(win_q), RX_WIN_CYC)) begin
            state_q <= RXS_ON;
            win_q   <= '0;
            hi_q    <= '0;
          end else begin
            win_q <= win_q + 1'b1;
          end
        end
        default: state_q <= RXS_IDLE;
      endcase
    end
  end

  assign active  = (state_q == RXS_ON);
  assign holding = (state_q == RXS_HOLD);
  assign win_cnt = win_q;
endmodule

// File: rtl/csq_tx_squelch.sv
module csq_tx_squelch
  import csq_pkg::*;
#(
  parameter int TX_MIN_LOW  = 2,
  parameter int TX_IDLE_CYC = 30,
  localparam int LO_W = cnt_width(TX_MIN_LOW),
  localparam int HI_W = cnt_width(TX_IDLE_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_s,
  output logic active
);
  logic            act_q;
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (!act_q) begin
      hi_q <= '0;
      if (tx_s) begin
        lo_q <= '0;
      end else if (run_done(32'(lo_q), TX_MIN_LOW)) begin
        act_q <= 1'b1;
        lo_q  <= '0;
      end else begin
        lo_q <= lo_q + 1'b1;
      end
    end else begin
      lo_q <= '0;
      if (!tx_s) begin
        hi_q <= '0;
      end else if (run_done(32'(hi_q), TX_IDLE_CYC)) begin
        act_q <= 1'b0;
        hi_q  <= '0;
      end else begin
        hi_q <= hi_q + 1'b1;
      end
    end
  end

  assign active = act_q;
endmodule

// File: rtl/carrier_squelch_top.sv
module carrier_squelch_top
  import csq_pkg::*;
#(
  parameter int RX_OFF_CYC  = 20,
  parameter int RX_WIN_CYC  = 100000,
  parameter int TX_MIN_LOW  = 2,
  parameter int TX_IDLE_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_sig_async,
  input  logic rx_line_async,
  input  logic tx_in_async,
  output logic rx_active,
  output logic rx_pos,
  output logic rx_neg,
  output logic tx_active
);
  localparam int WIN_W = cnt_width(RX_WIN_CYC);

  logic [2:0]       sync_v;
  logic             rx_sig_s;
  logic             rx_line_s;
  logic             tx_in_s;
  logic             rx_holding;
  logic [WIN_W-1:0] rx_win_cnt;

  // bit 0: comparator (idle 0), bit 1: rx line (idle 1), bit 2: tx input (idle 1)
  csq_sync2 #(.WIDTH(3), .RST_VAL(3'b110)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({tx_in_async, rx_line_async, rx_sig_async}),
    .q_sync  (sync_v)
  );

  assign rx_sig_s  = sync_v[0];
  assign rx_line_s = sync_v[1];
  assign tx_in_s   = sync_v[2];

  csq_rx_squelch #(.RX_OFF_CYC(RX_OFF_CYC), .RX_WIN_CYC(RX_WIN_CYC)) rx_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sig_s   (rx_sig_s),
    .line_s  (rx_line_s),
    .active  (rx_active),
    .holding (rx_holding),
    .win_cnt (rx_win_cnt)
  );

  csq_tx_squelch #(.TX_MIN_LOW(TX_MIN_LOW), .TX_IDLE_CYC(TX_IDLE_CYC)) tx_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_s   (tx_in_s),
    .active (tx_active)
  );

  // idle output pair sits at differential zero
  assign rx_pos = rx_active & rx_line_s;
  assign rx_neg = rx_active & ~rx_line_s;
endmodule

// File: rtl/csq_checker.sv
module csq_checker #(
  parameter int RX_WIN_CYC = 100000,
  parameter int WIN_W      = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_sig_s,
  input logic             rx_line_s,
  input logic             tx_in_s,
  input logic             rx_active,
  input logic             rx_holding,
  input logic             rx_pos,
  input logic             rx_neg,
  input logic             tx_active,
  input logic [WIN_W-1:0] rx_win_cnt
);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!rx_active && !tx_active && !rx_pos && !rx_neg));

  p_rx_start_needs_sig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(rx_sig_s));

  p_rx_stop_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_active) |-> ($past(rx_line_s) || !$past(rx_sig_s)));

  p_hold_exit_on_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_holding && !rx_sig_s) |=> !rx_active);

  p_win_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_win_cnt < WIN_W'(RX_WIN_CYC));

  p_rx_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active ? (rx_pos != rx_neg) : (!rx_pos && !rx_neg));

  p_tx_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> !$past(tx_in_s));

  p_tx_stop_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) |-> $past(tx_in_s));

  p_rx_sig_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_sig_s |=> !rx_active);
endmodule

bind carrier_squelch_top csq_checker #(
  .RX_WIN_CYC (RX_WIN_CYC),
  .WIN_W      (WIN_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_sig_s   (rx_sig_s),
  .rx_line_s  (rx_line_s),
  .tx_in_s    (tx_in_s),
  .rx_active  (rx_active),
  .rx_holding (rx_holding),
  .rx_pos     (rx_pos),
  .rx_neg     (rx_neg),
  .tx_active  (tx_active),
  .rx_win_cnt (rx_win_cnt)
);

// File: tb/carrier_squelch_top_tb_top.sv
module carrier_squelch_top_tb_top;
  localparam int OFF  = 5;
  localparam int WIN  = 40;
  localparam int MINL = 3;
  localparam int IDLE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig = 1'b0;
  logic line = 1'b1;
  logic txi = 1'b1;
  logic rx_active, rx_pos, rx_neg, tx_active;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  carrier_squelch_top #(
    .RX_OFF_CYC(OFF), .RX_WIN_CYC(WIN), .TX_MIN_LOW(MINL), .TX_IDLE_CYC(IDLE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_sig_async(sig), .rx_line_async(line),
    .tx_in_async(txi), .rx_active(rx_active), .rx_pos(rx_pos),
    .rx_neg(rx_neg), .tx_active(tx_active)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // bring receive to active with line low
  task automatic rx_open();
    sig = 1'b0; line = 1'b0; tick(4);
    sig = 1'b1; tick(4);
  endtask

  initial begin
    tick(2);
    chk("R1 in reset", {rx_active, tx_active, rx_pos, rx_neg}, 4'b0000);
    rst_n = 1'b1;
    tick(1);
    chk("R1 after release", {rx_active, tx_active, rx_pos, rx_neg}, 4'b0000);
    tick(3);

    // R7: inactive path ignores line toggles
    line = 1'b0; tick(3);
    chk("R7 idle low", {2'b00, rx_pos, rx_neg}, 4'b0000);
    line = 1'b1; tick(3);
    chk("R7 idle high", {2'b00, rx_pos, rx_neg}, 4'b0000);

    // R2/R3: exact receive latency
    line = 1'b0; sig = 1'b1;
    tick(2);
    chk("R2 rx not yet", {3'b000, rx_active}, 4'b0000);
    tick(1);
    chk("R3 rx on edge3", {3'b000, rx_active}, 4'b0001);

    // R7: pair follows line while active
    tick(2);
    chk("R7 active low", {2'b00, rx_pos, rx_neg}, 4'b0001);
    line = 1'b1; tick(3);
    chk("R7 active high", {2'b00, rx_pos, rx_neg}, 4'b0010);
    line = 1'b0; tick(3);

    // R10: comparator drop ends activity
    sig = 1'b0; tick(4);
    chk("R10 sig drop", {3'b000, rx_active}, 4'b0000);

    // R4: sweep of high run lengths
    for (int h = 1; h <= OFF + 2; h++) begin
      rx_open();
      line = 1'b1; tick(h);
      line = 1'b0; tick(3);
      chk($sformatf("R4 high run %0d", h), {3'b000, rx_active}, {3'b000, (h < OFF)});
    end

    // R5: drop within window keeps path closed, then rise reopens
    rx_open();
    line = 1'b1; tick(OFF + 4);
    line = 1'b0;
    chk("R5 fast off", {3'b000, rx_active}, 4'b0000);
    chk("R7 hold pair zero", {2'b00, rx_pos, rx_neg}, 4'b0000);
    sig = 1'b0; tick(WIN + 10);
    chk("R5 stays off", {3'b000, rx_active}, 4'b0000);
    sig = 1'b1; tick(4);
    chk("R5 reopen on rise", {3'b000, rx_active}, 4'b0001);

    // R6: sustained comparator reopens after window
    rx_open();
    line = 1'b1; tick(OFF + 4);
    line = 1'b0;
    tick(WIN - 8);
    chk("R6 still in window", {3'b000, rx_active}, 4'b0000);
    tick(12);
    chk("R6 reopen after window", {3'b000, rx_active}, 4'b0001);
    sig = 1'b0; tick(4);

    // R2/R8: exact transmit latency
    txi = 1'b0;
    tick(MINL + 1);
    chk("R2 tx not yet", {3'b000, tx_active}, 4'b0000);
    tick(1);
    chk("R8 tx on", {3'b000, tx_active}, 4'b0001);
    txi = 1'b1; tick(IDLE + 6);
    chk("R9 tx idle end", {3'b000, tx_active}, 4'b0000);

    // R8: sweep of low pulse widths
    for (int w = 1; w <= MINL + 2; w++) begin
      txi = 1'b0; tick(w);
      txi = 1'b1; tick(3);
      chk($sformatf("R8 low pulse %0d", w), {3'b000, tx_active}, {3'b000, (w >= MINL)});
      tick(IDLE + 4);
    end

    // R9: sweep of high run lengths, each broken by a short low
    for (int h = 1; h <= IDLE + 2; h++) begin
      txi = 1'b0; tick(MINL + 4);
      txi = 1'b1; tick(h);
      txi = 1'b0; tick(MINL - 1);
      txi = 1'b1; tick(3);
      chk($sformatf("R9 high run %0d", h), {3'b000, tx_active}, {3'b000, (h < IDLE)});
      tick(IDLE + 4);
    end

    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule